// File: doc/BRIEF.md
# Serial and Parallel Configuration Word Loader

This block collects the configuration word of a frequency synthesizer and holds it steady for the rest of the chip. The word has three fields: a 3-bit test selector, a 2-bit output-divider code and a 9-bit feedback-divider code. The word can arrive over a three-wire serial port, or the two divider fields can be captured straight from a parallel bus.

On the serial side, each rising edge of the serial clock moves one data bit into a 14-bit shift register. A frame carries the bits in this order: test selector MSB first, then the output divider, then the feedback divider, ending with its LSB. After 14 edges the first bit sits at the top of the register. While the serial load strobe is high, the holding registers follow the shift register. When the strobe falls they keep their value.

A parallel load strobe captures both divider fields from the bus and clears the test selector. The register's top bit is always brought out, so a test pin can show the shifted data. All pins are asynchronous to the system clock. They pass through a common synchronizer, and the holding registers are clocked by the system clock. An asynchronous active-low reset clears all state.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted, and at release, cfg_t, cfg_n, cfg_m and ser_tail are all zero.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of the 14-bit shift register and moves every bit one place up. ser_tail (bit 13) equals the bit shifted in 14 edges earlier.
- R3: Frame mapping: shift-register bits [13:11] form the test field (first bit received = test bit 2), bits [10:9] form the output-divider field and bits [8:0] form the feedback-divider field (last bit received = feedback bit 0).
- R4: While ser_load is high and par_load is low, cfg_t, cfg_n and cfg_m follow the shift register, including shifts that occur during the high phase.
- R5: While both strobes are low, cfg_t, cfg_n and cfg_m hold their value, even when serial bits keep shifting.
- R6: While par_load is high, cfg_m takes par_m, cfg_n takes par_n and cfg_t becomes zero.
- R7: When both strobes are high, the parallel path wins: cfg_m and cfg_n take the bus and cfg_t is zero.
- R8: A falling edge of ser_clk, or a change of ser_data without a rising ser_clk edge, does not alter the shift register.
- R9: Pin changes reach the outputs within four system-clock cycles, after SYNC_STAGES synchronizer flops plus one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_load | input | 1 | Serial load strobe, level-sensitive |
| par_load | input | 1 | Parallel load strobe, level-sensitive |
| par_m | input | 9 | Parallel feedback-divider code |
| par_n | input | 2 | Parallel output-divider code |
| cfg_t | output | 3 | Held test-selector field |
| cfg_n | output | 2 | Held output-divider field |
| cfg_m | output | 9 | Held feedback-divider field |
| ser_tail | output | 1 | Top bit of the shift register |

## Verification
Several rules are checked every cycle by the assertions:
- one shift step per detected rising edge, and a stable register otherwise;
- the parallel strobe clearing the test field and loading the bus;
- the serial strobe copying the register;
- the holding registers staying put when no strobe is active.

Other behaviours can only be shown by the bench's scenarios: the end-to-end frame bit order and field mapping, the 14-edge delay to the tail, the priority outcome when both strobes overlap, and the pin-level latency. These are checked against a frame model that the bench keeps for itself.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int unsigned DEF_T_W = 3;
   localparam int unsigned DEF_N_W = 2;
   localparam int unsigned DEF_M_W = 9;
   localparam int unsigned DEF_SYNC = 2;

   typedef enum logic [1:0] {
      LD_HOLD     = 2'd0,
      LD_SERIAL   = 2'd1,
      LD_PARALLEL = 2'd2
   } load_act_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cfg_sync: WIDTH must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
   parameter int unsigned FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdata_s,
   output logic [FRAME_W-1:0] frame_q,
   output logic               shift_pulse
);
   logic sclk_prev;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("cfg_shift: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign shift_pulse = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (shift_pulse) begin
         frame_q <= {frame_q[FRAME_W-2:0], sdata_s};
      end
   end

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> (frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])
                       && frame_q[0] == $past(sdata_s))); // R2
   AST_NO_EDGE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_pulse |=> $stable(frame_q)); // R8
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
   import cfg_loader_pkg::*;
#(
   parameter int unsigned T_W = DEF_T_W,
   parameter int unsigned N_W = DEF_N_W,
   parameter int unsigned M_W = DEF_M_W,
   localparam int unsigned FRAME_W = T_W + N_W + M_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sload_s,
   input  logic               pload_s,
   input  logic [M_W-1:0]     par_m_s,
   input  logic [N_W-1:0]     par_n_s,
   input  logic [FRAME_W-1:0] frame,
   output logic [T_W-1:0]     cfg_t,
   output logic [N_W-1:0]     cfg_n,
   output logic [M_W-1:0]     cfg_m
);
   localparam int unsigned N_LO = M_W;
   localparam int unsigned T_LO = M_W + N_W;

   load_act_e act;

   generate
      if (T_W < 1 || N_W < 1 || M_W < 1) begin : g_bad_fields
         $error("cfg_hold: every field needs at least one bit");
      end
   endgenerate

   always_comb begin
      if (pload_s)      act = LD_PARALLEL;
      else if (sload_s) act = LD_SERIAL;
      else              act = LD_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_t <= '0;
         cfg_n <= '0;
         cfg_m <= '0;
      end else begin
         case (act)
            LD_PARALLEL: begin
               cfg_t <= '0;
               cfg_n <= par_n_s;
               cfg_m <= par_m_s;
            end
            LD_SERIAL: begin
               cfg_t <= frame[T_LO +: T_W];
               cfg_n <= frame[N_LO +: N_W];
               cfg_m <= frame[0 +: M_W];
            end
            default: ;
         endcase
      end
   end

   AST_PLOAD_CLEARS_T: assert property (@(posedge clk) disable iff (!rst_n)
      pload_s |=> (cfg_t == '0)); // R6
   AST_PLOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pload_s && sload_s) |=> (cfg_m == $past(par_m_s) && cfg_n == $past(par_n_s))); // R7
   AST_SLOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (sload_s && !pload_s) |=> ({cfg_t, cfg_n, cfg_m} == $past(frame))); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sload_s && !pload_s) |=> ($stable(cfg_t) && $stable(cfg_n) && $stable(cfg_m))); // R5
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int unsigned T_W         = DEF_T_W,
   parameter int unsigned N_W         = DEF_N_W,
   parameter int unsigned M_W         = DEF_M_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   input  logic           par_load,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   output logic [T_W-1:0] cfg_t,
   output logic [N_W-1:0] cfg_n,
   output logic [M_W-1:0] cfg_m,
   output logic           ser_tail
);
   localparam int unsigned FRAME_W = T_W + N_W + M_W;
   localparam int unsigned BUS_W   = 4 + M_W + N_W;

   logic [BUS_W-1:0]   pins_s;
   logic               sclk_s, sdata_s, sload_s, pload_s;
   logic [M_W-1:0]     par_m_s;
   logic [N_W-1:0]     par_n_s;
   logic [FRAME_W-1:0] frame_q;
   logic               shift_pulse;

   generate
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("cfg_loader: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   cfg_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ser_clk, ser_data, ser_load, par_load, par_m, par_n}),
      .d_out (pins_s)
   );

   assign {sclk_s, sdata_s, sload_s, pload_s, par_m_s, par_n_s} = pins_s;

   cfg_shift #(.FRAME_W(FRAME_W)) i_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (sclk_s),
      .sdata_s     (sdata_s),
      .frame_q     (frame_q),
      .shift_pulse (shift_pulse)
   );

   cfg_hold #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .sload_s (sload_s),
      .pload_s (pload_s),
      .par_m_s (par_m_s),
      .par_n_s (par_n_s),
      .frame   (frame_q),
      .cfg_t   (cfg_t),
      .cfg_n   (cfg_n),
      .cfg_m   (cfg_m)
   );

   assign ser_tail = frame_q[FRAME_W-1];

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (cfg_t == '0 && cfg_n == '0 && cfg_m == '0 && !ser_tail)); // R1
   AST_ONE_STEP_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> (ser_tail == $past(frame_q[FRAME_W-2]))); // R2
endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b0;
   logic [8:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic [2:0] cfg_t;
   logic [1:0] cfg_n;
   logic [8:0] cfg_m;
   logic       ser_tail;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [13:0] mdl = '0;
   logic [13:0] held = '0;

   always #10 clk = ~clk;

   cfg_loader i_cfg_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
      .cfg_t(cfg_t), .cfg_n(cfg_n), .cfg_m(cfg_m), .ser_tail(ser_tail)
   );

   function automatic logic [2:0] f_t(input logic [13:0] f); return f[13:11]; endfunction
   function automatic logic [1:0] f_n(input logic [13:0] f); return f[10:9];  endfunction
   function automatic logic [8:0] f_m(input logic [13:0] f); return f[8:0];   endfunction

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_cfg(input string req, input logic [13:0] exp);
      check(req, {29'd0, cfg_t}, {29'd0, f_t(exp)});
      check(req, {30'd0, cfg_n}, {30'd0, f_n(exp)});
      check(req, {23'd0, cfg_m}, {23'd0, f_m(exp)});
   endtask

   task automatic shift_bit(input logic b);
      ser_data = b;
      settle();
      ser_clk = 1'b1;
      settle();
      mdl = {mdl[12:0], b};
      ser_clk = 1'b0;
      settle();
   endtask

   task automatic shift_frame(input logic [13:0] f);
      for (int i = 13; i >= 0; i--) shift_bit(f[i]);
   endtask

   task automatic pulse_sload();
      ser_load = 1'b1;
      settle();
      held = mdl;
      ser_load = 1'b0;
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 reset t", {29'd0, cfg_t}, 32'd0);
      check("R1 reset m", {23'd0, cfg_m}, 32'd0);
      check("R1 reset tail", {31'd0, ser_tail}, 32'd0);
      rst_n = 1'b1;
      settle();
      check_cfg("R1 after release", 14'd0);

      // R3 directed frame: T=5, N=2, M=0x199
      shift_frame(14'b101_10_110011001);
      check("R2 tail is first bit", {31'd0, ser_tail}, 32'd1);
      pulse_sload();
      check("R3 t field", {29'd0, cfg_t}, 32'd5);
      check("R3 n field", {30'd0, cfg_n}, 32'd2);
      check("R3 m field", {23'd0, cfg_m}, 32'h199);

      // R5 strobes low: shifting does not disturb held values
      for (int i = 0; i < 5; i++) shift_bit(1'($urandom));
      check_cfg("R5 hold while idle", held);

      // R4 follow during ser_load high, including new shifts
      ser_load = 1'b1;
      settle();
      check_cfg("R4 follow", mdl);
      shift_bit(1'b1);
      check_cfg("R4 follow new shift", mdl);

      // R8 falling edge / data toggles without rising edge
      ser_clk = 1'b1;
      settle();
      mdl = {mdl[12:0], ser_data};
      ser_data = ~ser_data;
      settle();
      ser_clk = 1'b0;
      settle();
      ser_data = ~ser_data;
      settle();
      check_cfg("R8 no shift on fall or data", mdl);
      check("R8 tail", {31'd0, ser_tail}, {31'd0, mdl[13]});
      ser_load = 1'b0;
      settle();
      held = mdl;

      // R6 parallel load
      par_m = 9'h0A5;
      par_n = 2'd3;
      settle();
      par_load = 1'b1;
      settle();
      par_load = 1'b0;
      settle();
      held = {3'd0, 2'd3, 9'h0A5};
      check_cfg("R6 parallel load clears t", held);

      // R9 latency: strobe change visible within four cycles
      par_m = 9'h1FF;
      par_n = 2'd1;
      par_load = 1'b1;
      settle();
      check("R9 latency", {23'd0, cfg_m}, 32'h1FF);
      par_load = 1'b0;
      settle();
      held = {3'd0, 2'd1, 9'h1FF};

      // R7 both strobes high
      shift_frame(14'b111_00_000000011);
      par_m = 9'h03C;
      par_n = 2'd2;
      ser_load = 1'b1;
      par_load = 1'b1;
      settle();
      check_cfg("R7 parallel wins", {3'd0, 2'd2, 9'h03C});
      par_load = 1'b0;
      settle();
      check_cfg("R4 serial after parallel release", mdl);
      ser_load = 1'b0;
      settle();

      // Random frames: R2 and R3
      for (int k = 0; k < 25; k++) begin
         logic [13:0] fr;
         fr = 14'($urandom);
         shift_frame(fr);
         check("R2 random tail", {31'd0, ser_tail}, {31'd0, fr[13]});
         if ($urandom % 3 == 0) begin
            par_m = 9'($urandom);
            par_n = 2'($urandom);
            par_load = 1'b1;
            settle();
            par_load = 1'b0;
            settle();
            check_cfg("R6 random parallel", {3'd0, par_n, par_m});
         end else begin
            pulse_sload();
            check_cfg("R3 random frame", fr);
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule